// File: doc/BRIEF.md
# SPI Master with Auto-Read Receive Streaming

This block is an 8-bit SPI master that sits on a small register bus. Software sets the bit order, clock polarity, the transmit and receive clock phases and the SCLK half-period. A single write to the transmit register then shifts one byte out on MOSI while a byte is sampled in from MISO. Two status flags, transmit-empty and receive-full, are both set when the exchange is complete. Software polls for both flags. Chip select is handled outside the block.

For long reads there is an auto-read mode. When it is on, every read of the receive register launches the next exchange, and the byte driven out is the last one written to the transmit register. A receive-request output signals that a received byte is waiting. A single-byte DMA reader can therefore stream a burst with no transmit writes in between. An exchange that is requested while the shifter is busy is dropped, and a sticky overrun flag records it.

Register map (3-bit address): 0 activate, 1 control, 2 clock control, 3 divider, 4 status, 5 transmit data, 6 receive data. Read data is registered and appears one cycle after the read strobe.

Top module: `spi_ar_master`

## Requirements
- R1: Activate bit 0 enables the block. While it is 0, SCLK rests at its idle level, a transmit write starts no exchange (not even after re-enabling), and status transmit-empty stays 1.
- R2: Control bit 0 selects the bit order: 0 shifts MSB first and 1 shifts LSB first. The order applies to both the transmitted and the received byte.
- R3: Control bits 3:2 hold the data-in mode. The value 00 is full duplex: the byte written is driven on MOSI and a whole byte is captured from MISO in the same exchange.
- R4: Clock control bit 0 is the polarity and sets the idle level of SCLK. Bit 1 is the transmit phase and bit 2 is the receive phase. With phase 0, data is launched before the first SCLK edge of each bit and sampled on the leading edge. With phase 1, data is launched on the leading edge and sampled on the trailing edge.
- R5: A transmit-data write while the block is enabled and idle starts exactly one exchange of 16 SCLK edges (8 clock periods).
- R6: Status bit 0 (transmit-empty) goes to 0 when an exchange starts and stays 0 while it runs. Status bit 1 (receive-full) is set when the exchange ends. The exchange is complete once both bits read 1.
- R7: With control bit 5 set, each read of the receive-data register returns the held byte and starts a new exchange that sends the last byte written to transmit data.
- R8: A read of the receive-data register clears receive-full. The output rx_req is 1 exactly while receive-full and auto-read are both set.
- R9: The divider register sets the SCLK half-period in system clock cycles. A value of 0 acts as 1.
- R10: A transmit write or an auto-read trigger that arrives while an exchange is running is ignored, and the transmit byte is not updated. Status bit 2 (overrun) is then set and stays set until a status write with bit 2 = 1.
- R11: After reset the status register reads 0x01, activate reads 0, SCLK and MOSI are 0 and rx_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| rx_req | output | 1 | Received byte waiting in auto-read mode |

## Verification
The bench runs the exchange against a behavioural slave. The vector table covers both polarities, both phase pairs and both bit orders, with divider values 0, 1, 2, 3 and 4. The vectors use asymmetric bytes such as 0x3C/0xA7 and 0x12/0xC3, so a reversed order, a shifted sample point or a wrong launch edge each give a different byte at one end. The count of active SCLK cycles sets the half-period apart from the edge count. Directed runs cover:
- a three-byte auto-read burst, to separate the read trigger from the write trigger;
- a transmit write during a running exchange, for the overrun case;
- transmit writes while disabled.

// File: rtl/spi_ar_pkg.sv
package spi_ar_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_ACT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLK  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd5;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd6;

  localparam int C_LSB  = 0;
  localparam int C_DIN  = 2;
  localparam int C_AUTO = 5;
  localparam int K_POL  = 0;
  localparam int K_TXPH = 1;
  localparam int K_RXPH = 2;
  localparam int S_TXE  = 0;
  localparam int S_RXF  = 1;
  localparam int S_OVR  = 2;

  typedef struct packed {
    logic lsb_first;
    logic cpol;
    logic tx_ph;
    logic rx_ph;
  } spi_mode_t;
endpackage

// File: rtl/spi_ar_regs.sv
module spi_ar_regs
  import spi_ar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              start,
  output logic [DATA_W-1:0] start_byte,
  output spi_mode_t         mode,
  output logic [DATA_W-1:0] div,
  output logic              act,
  output logic              txe,
  output logic              rxf,
  output logic              ovr,
  output logic              rx_req
);
  logic              lsb_q, auto_q;
  logic [1:0]        din_q;
  logic [2:0]        clk_q;
  logic [DATA_W-1:0] tx_hold, rx_hold;
  logic              tx_wr, rx_rd, trig;

  // Trigger decode: a transmit write, or a receive read in auto-read mode.
  always_comb begin
    tx_wr      = bus_wr && (bus_addr == A_TXD);
    rx_rd      = bus_rd && (bus_addr == A_RXD);
    trig       = act && (tx_wr || (rx_rd && auto_q));
    start      = trig && !busy;
    start_byte = tx_wr ? bus_wdata : tx_hold;
  end

  assign mode   = '{lsb_first: lsb_q, cpol: clk_q[K_POL], tx_ph: clk_q[K_TXPH], rx_ph: clk_q[K_RXPH]};
  assign rx_req = auto_q && rxf;

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= 1'b0;
      lsb_q     <= 1'b0;
      din_q     <= 2'b00;
      auto_q    <= 1'b0;
      clk_q     <= 3'b000;
      div       <= DATA_W'(1);
      tx_hold   <= '0;
      rx_hold   <= '0;
      txe       <= 1'b1;
      rxf       <= 1'b0;
      ovr       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_ACT:  act <= bus_wdata[0];
          A_CTRL: begin
            lsb_q  <= bus_wdata[C_LSB];
            din_q  <= bus_wdata[C_DIN+1:C_DIN];
            auto_q <= bus_wdata[C_AUTO];
          end
          A_CLK:  clk_q <= bus_wdata[2:0];
          A_DIV:  div <= bus_wdata;
          A_STAT: if (bus_wdata[S_OVR]) ovr <= 1'b0;
          A_TXD:  if (!busy) tx_hold <= bus_wdata;
          default: ;
        endcase
      end
      if (done) begin
        rx_hold <= rx_byte;
        rxf     <= 1'b1;
        txe     <= 1'b1;
      end else if (rx_rd) begin
        rxf <= 1'b0;
      end
      if (trig && busy) ovr <= 1'b1;
      if (start) txe <= 1'b0;
      if (bus_rd) begin
        case (bus_addr)
          A_ACT:   bus_rdata <= DATA_W'(act);
          A_CTRL:  bus_rdata <= DATA_W'({auto_q, 1'b0, din_q, 1'b0, lsb_q});
          A_CLK:   bus_rdata <= DATA_W'(clk_q);
          A_DIV:   bus_rdata <= div;
          A_STAT:  bus_rdata <= DATA_W'({ovr, rxf, txe});
          A_TXD:   bus_rdata <= tx_hold;
          A_RXD:   bus_rdata <= rx_hold;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_ar_engine.sv
module spi_ar_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic [DATA_W-1:0] start_byte,
  input  logic [DATA_W-1:0] div,
  input  logic              lsb_first,
  input  logic              cpol,
  input  logic              tx_ph,
  input  logic              rx_ph,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = b[DATA_W-1-i];
    return r;
  endfunction

  logic [DATA_W-1:0] div_cnt, div_top, sh_tx, sh_rx, ld, rx_nxt;
  logic [EW-1:0]     edge_cnt;
  logic              tick, lead, smp, drv;

  always_comb begin
    div_top = (div == '0) ? '0 : div - 1'b1;
    tick    = busy && (div_cnt == div_top);
    lead    = ~edge_cnt[0];
    smp     = lead ? ~rx_ph : rx_ph;
    drv     = lead ? tx_ph : (~tx_ph && (edge_cnt != LAST));
    rx_nxt  = smp ? {sh_rx[DATA_W-2:0], miso} : sh_rx;
    ld      = lsb_first ? flip(start_byte) : start_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      rx_byte  <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
        sclk <= cpol;
      end else if (!busy) begin
        sclk <= cpol;
        if (start) begin
          busy     <= 1'b1;
          div_cnt  <= '0;
          edge_cnt <= '0;
          if (!tx_ph) begin
            mosi  <= ld[DATA_W-1];
            sh_tx <= {ld[DATA_W-2:0], 1'b0};
          end else begin
            sh_tx <= ld;
          end
        end
      end else if (tick) begin
        div_cnt  <= '0;
        sclk     <= ~sclk;
        sh_rx    <= rx_nxt;
        edge_cnt <= edge_cnt + 1'b1;
        if (drv) begin
          mosi  <= sh_tx[DATA_W-1];
          sh_tx <= {sh_tx[DATA_W-2:0], 1'b0};
        end
        if (edge_cnt == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          sclk    <= cpol;
          rx_byte <= lsb_first ? flip(rx_nxt) : rx_nxt;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_ar_master.sv
module spi_ar_master
  import spi_ar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              rx_req
);
  logic              start_w, busy_w, done_w, act_w, txe_w, rxf_w, ovr_w;
  logic [DATA_W-1:0] start_byte_w, rx_byte_w, div_w;
  spi_mode_t         mode_w;

  spi_ar_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy_w),
    .done       (done_w),
    .rx_byte    (rx_byte_w),
    .start      (start_w),
    .start_byte (start_byte_w),
    .mode       (mode_w),
    .div        (div_w),
    .act        (act_w),
    .txe        (txe_w),
    .rxf        (rxf_w),
    .ovr        (ovr_w),
    .rx_req     (rx_req)
  );

  spi_ar_engine #(.DATA_W(DATA_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .en         (act_w),
    .start      (start_w),
    .start_byte (start_byte_w),
    .div        (div_w),
    .lsb_first  (mode_w.lsb_first),
    .cpol       (mode_w.cpol),
    .tx_ph      (mode_w.tx_ph),
    .rx_ph      (mode_w.rx_ph),
    .miso       (spi_miso),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .busy       (busy_w),
    .done       (done_w),
    .rx_byte    (rx_byte_w)
  );
endmodule

// File: rtl/spi_ar_master_chk.sv
module spi_ar_master_chk
  import spi_ar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              act,
  input logic              busy,
  input logic              done,
  input logic              sclk,
  input logic              cpol,
  input logic              txe,
  input logic              rxf,
  input logic              ovr
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CW    = $clog2(EDGES + 1) + 1;

  logic [CW-1:0] n_tog;
  logic          sclk_d;

  always_ff @(posedge clk) begin
    sclk_d <= sclk;
    if (rst || !busy) n_tog <= '0;
    else if (sclk != sclk_d) n_tog <= n_tog + 1'b1;
  end

  // R1: once the block is disabled the shifter is idle on the next cycle
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !act |=> !busy);

  // R5: a completed exchange produced exactly 2*DATA_W SCLK transitions
  a_r5_edge_count: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && done) |-> (32'(n_tog) + 32'(sclk != sclk_d)) == EDGES);

  // R4: SCLK rests at the programmed polarity whenever no exchange runs
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && $stable(cpol)) |-> (sclk == cpol));

  // R6: transmit-empty is low throughout a running exchange
  a_r6_txe_low_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !txe);

  // R8: a receive read with no completion in the same cycle empties the buffer
  a_r8_rxf_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_RXD && !done) |=> !rxf);

  // R10: overrun holds until cleared by a status write
  a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr && !(bus_wr && bus_addr == A_STAT && bus_wdata[S_OVR])) |=> ovr);
endmodule

bind spi_ar_master spi_ar_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .act       (act_w),
  .busy      (busy_w),
  .done      (done_w),
  .sclk      (spi_sclk),
  .cpol      (mode_w.cpol),
  .txe       (txe_w),
  .rxf       (rxf_w),
  .ovr       (ovr_w)
);

// File: tb/spi_ar_master_tb.sv
module spi_ar_master_tb;
  import spi_ar_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_sclk, spi_mosi, rx_req;
  logic       spi_miso = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_ar_master u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rx_req(rx_req)
  );

  // Behavioural slave, MSB-first on the wire, evaluated away from the active edge
  logic       s_cpol = 0, s_cpha = 0, s_prev = 0;
  logic [7:0] s_q [4];
  logic [7:0] s_cap [4];
  logic [7:0] s_tx = 0, s_rx = 0;
  int         s_idx = 0, s_nb = 0, s_ncap = 0, s_edges = 0, s_active = 0;

  always @(negedge clk) begin
    if (spi_sclk !== s_prev) begin
      s_edges++;
      if ((spi_sclk != s_cpol) ^ s_cpha) begin
        s_rx = {s_rx[6:0], spi_mosi};
        s_nb++;
        if (s_nb == 8) begin
          if (s_ncap < 4) s_cap[s_ncap] = s_rx;
          s_ncap++;
          s_nb = 0;
          if (s_cpha) begin
            s_tx = s_q[s_idx % 4];
            s_idx++;
          end
        end
      end else begin
        if (!s_cpha && s_nb == 0) begin
          spi_miso = s_q[s_idx % 4][7];
          s_tx = {s_q[s_idx % 4][6:0], 1'b0};
          s_idx++;
        end else begin
          spi_miso = s_tx[7];
          s_tx = {s_tx[6:0], 1'b0};
        end
      end
    end
    if (spi_sclk != s_cpol) s_active++;
    s_prev = spi_sclk;
  end

  task automatic slave_arm(input logic pol, input logic pha);
    s_cpol = pol; s_cpha = pha; s_prev = spi_sclk;
    s_nb = 0; s_ncap = 0; s_edges = 0; s_active = 0;
    s_rx = 0;
    if (!pha) begin
      spi_miso = s_q[0][7];
      s_tx = {s_q[0][6:0], 1'b0};
    end else begin
      s_tx = s_q[0];
    end
    s_idx = 1;
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic wait_complete(output logic [7:0] s);
    s = 0;
    for (int k = 0; k < 1000; k++) begin
      reg_rd(A_STAT, s);
      if (s[1:0] == 2'b11) break;
    end
  endtask

  // {clock ctrl[2:0], lsb_first, divider, tx byte, slave byte}
  localparam logic [27:0] VEC [6] = '{
    {3'b000, 1'b0, 8'd1, 8'h3C, 8'hA7},
    {3'b001, 1'b0, 8'd2, 8'h81, 8'h5E},
    {3'b110, 1'b0, 8'd3, 8'hF0, 8'h0F},
    {3'b111, 1'b1, 8'd1, 8'h12, 8'hC3},
    {3'b000, 1'b1, 8'd0, 8'h6B, 8'h94},
    {3'b110, 1'b1, 8'd4, 8'hFF, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, st;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(spi_sclk == 0 && spi_mosi == 0, "R11 sclk/mosi", {spi_sclk, spi_mosi}, 0);
    check(rx_req == 0, "R11 rx_req", rx_req, 0);
    reg_rd(A_STAT, d);
    check(d == 8'h01, "R11 status", d, 8'h01);
    reg_rd(A_ACT, d);
    check(d == 8'h00, "R11 activate", d, 0);

    reg_wr(A_ACT, 8'h01);
    for (int v = 0; v < 6; v++) begin
      logic [2:0] cc; logic lsb; logic [7:0] dv, txb, slb;
      int hp;
      {cc, lsb, dv, txb, slb} = VEC[v];
      hp = (dv == 0) ? 1 : int'(dv);
      reg_wr(A_CLK, {5'b0, cc});
      reg_wr(A_CTRL, {7'b0, lsb});
      reg_wr(A_DIV, dv);
      repeat (2) @(negedge clk);
      s_q[0] = slb;
      slave_arm(cc[K_POL], cc[K_TXPH]);
      reg_wr(A_TXD, txb);
      wait_complete(st);
      check(st[1:0] == 2'b11, "R6 completion flags", st, 3);
      check(spi_sclk == cc[K_POL], "R4 idle level", spi_sclk, cc[K_POL]);
      check(s_edges == 16, "R5 edge count", s_edges, 16);
      check(s_active == 8 * hp, "R9 half-period", s_active, 8 * hp);
      check(s_cap[0] == (lsb ? rev8(txb) : txb), "R2/R3 mosi byte", s_cap[0], lsb ? rev8(txb) : txb);
      reg_rd(A_RXD, d);
      check(d == (lsb ? rev8(slb) : slb), "R2/R3/R4 rx byte", d, lsb ? rev8(slb) : slb);
    end

    // R7 / R8 auto-read burst
    reg_wr(A_CLK, 8'h00);
    reg_wr(A_DIV, 8'd2);
    reg_wr(A_CTRL, 8'h20);
    repeat (2) @(negedge clk);
    s_q[0] = 8'h9A; s_q[1] = 8'h3E; s_q[2] = 8'h71; s_q[3] = 8'h00;
    slave_arm(0, 0);
    reg_wr(A_TXD, 8'hC6);
    for (int b = 0; b < 3; b++) begin
      for (int k = 0; k < 200 && !rx_req; k++) @(negedge clk);
      check(rx_req == 1, "R8 rx_req high", rx_req, 1);
      if (b == 2) reg_wr(A_CTRL, 8'h00);
      reg_rd(A_RXD, d);
      check(d == s_q[b], "R7 auto-read byte", d, s_q[b]);
      check(rx_req == 0, "R8 rx_req after read", rx_req, 0);
    end
    repeat (60) @(negedge clk);
    check(s_ncap == 3, "R7 exchange count", s_ncap, 3);
    for (int b = 0; b < 3; b++)
      check(s_cap[b] == 8'hC6, "R7 resent tx byte", s_cap[b], 8'hC6);

    // R10 overrun
    reg_wr(A_DIV, 8'd4);
    s_q[0] = 8'h4D;
    slave_arm(0, 0);
    reg_wr(A_TXD, 8'h11);
    reg_wr(A_TXD, 8'h22);
    wait_complete(st);
    check(st[2] == 1, "R10 overrun set", st, 8'h07);
    check(s_cap[0] == 8'h11 && s_ncap == 1, "R10 write ignored", s_cap[0], 8'h11);
    reg_rd(A_TXD, d);
    check(d == 8'h11, "R10 tx byte kept", d, 8'h11);
    reg_rd(A_RXD, d);
    check(d == 8'h4D, "R10 rx byte", d, 8'h4D);
    reg_rd(A_STAT, st);
    check(st[2] == 1, "R10 overrun sticky", st, 8'h05);
    reg_wr(A_STAT, 8'h04);
    reg_rd(A_STAT, st);
    check(st == 8'h01, "R10 overrun cleared", st, 8'h01);

    // R1 disabled
    reg_wr(A_ACT, 8'h00);
    slave_arm(0, 0);
    reg_wr(A_TXD, 8'h5A);
    repeat (40) @(negedge clk);
    check(s_edges == 0, "R1 no edges while off", s_edges, 0);
    reg_rd(A_STAT, st);
    check(st == 8'h01, "R1 status while off", st, 8'h01);
    reg_wr(A_ACT, 8'h01);
    repeat (80) @(negedge clk);
    check(s_edges == 0 && spi_sclk == 0, "R1 no deferred start", s_edges, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule